// File: doc/BRIEF.md
# Dual-Register Output Logic Cell Bank

This block models the output logic of a small programmable logic device as a bank of identical cells. Each cell holds two one-bit registers. Each register takes its next-state input from its own sum-of-products term and can work as a plain data register or as a toggle register. Each register picks its own clock: either a private clock product term or the clock pin shared by the whole bank. Each register can also be cleared at once by its own reset term. A single synchronous preset is shared by every register in the bank, and a preload path lets a test harness force any register contents.

Only one register of each cell drives the cell's pin. A configuration bit chooses which one, and the other register stays buried. The pin driver is gated by an output-enable term for that cell. Both registers always return to the array as feedback, and so does the level seen on the pin. All configuration bits are static inputs.

The design runs on one fabric clock `clk`. Clock sources (product terms and the clock pin) are sampled on that clock. A register's *active edge* is a `clk` edge at which its selected source is sampled high after it was sampled low at the previous `clk` edge. While `rst` is high, the stored previous sample is forced high, so a source that is held high through reset gives no edge.

Top module: `olc_bank`

## Requirements
- R1: While `rst` is high at a `clk` edge, every register is cleared to 0 and every feedback output reads 0 from the next cycle on.
- R2: A register in data mode (`cfg_tog` bit = 0) takes the value of its sum term on its active edge.
- R3: A register in toggle mode (`cfg_tog` bit = 1) inverts on its active edge when its sum term is 1, and keeps its value when the sum term is 0.
- R4: A register with no active edge keeps its value, whatever its sum term does.
- R5: With `cfg_pinclk` bit = 1 a register is clocked only by `clk_pin`. With bit = 0 it is clocked only by its own clock term. The source that is not selected has no effect.
- R6: While a register's reset term is 1, its feedback output reads 0 in that same cycle, and the stored value is 0 after that edge.
- R7: On an active edge with `sync_preset` = 1, a register is set to 1 instead of taking its data or toggle value. Without an active edge, the preset has no effect.
- R8: Priority, from highest: `rst`, reset term, preload, preset, data/toggle update.
- R9: While `load_en` = 1, each register stores its preload bit at every `clk` edge, with or without an active edge.
- R10: `pad_out` of a cell carries the first register (`cfg_pin_sel` bit = 0) or the second register (bit = 1). Both registers always appear on `fb_a` and `fb_b`.
- R11: `pad_oe` follows the cell's output-enable term, and `fb_pad` follows `pad_in` at all times, whether or not the driver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| clk_pin | input | 1 | Shared dedicated clock pin level |
| sync_preset | input | 1 | Bank-wide synchronous preset |
| load_en | input | 1 | Preload enable for all registers |
| load_a | input | NUM_CELLS | Preload bits, first registers |
| load_b | input | NUM_CELLS | Preload bits, second registers |
| sum_a | input | NUM_CELLS | Sum terms, first registers |
| sum_b | input | NUM_CELLS | Sum terms, second registers |
| tclk_a | input | NUM_CELLS | Clock product terms, first registers |
| tclk_b | input | NUM_CELLS | Clock product terms, second registers |
| arst_a | input | NUM_CELLS | Reset terms, first registers |
| arst_b | input | NUM_CELLS | Reset terms, second registers |
| oe_term | input | NUM_CELLS | Output-enable terms, one per cell |
| cfg_tog_a | input | NUM_CELLS | Toggle mode, first registers |
| cfg_tog_b | input | NUM_CELLS | Toggle mode, second registers |
| cfg_pinclk_a | input | NUM_CELLS | Pin-clock select, first registers |
| cfg_pinclk_b | input | NUM_CELLS | Pin-clock select, second registers |
| cfg_pin_sel | input | NUM_CELLS | Pin source: 0 first, 1 second register |
| pad_in | input | NUM_CELLS | Level seen on each pin |
| pad_out | output | NUM_CELLS | Pin drive value |
| pad_oe | output | NUM_CELLS | Pin driver enable |
| fb_a | output | NUM_CELLS | Feedback of first registers |
| fb_b | output | NUM_CELLS | Feedback of second registers |
| fb_pad | output | NUM_CELLS | Feedback of pin levels |

## Verification
The bench builds the bank with NUM_CELLS = 4 and gives each cell a different setting. All four pairings of data/toggle mode with term/pin clock are then live at once, and each pin selection is used at the same time. That lets a single random stream show crosstalk between the shared pin clock and private clock terms, as well as priority clashes among reset term, preload and preset. A second configuration pass swaps the settings, so each register slot also runs in the opposite mode.

// File: rtl/olc_pkg.sv
package olc_pkg;
  localparam int REGS_PER_CELL = 2;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } flop_mode_e;

  typedef enum logic {
    SRC_TERM = 1'b0,
    SRC_PIN  = 1'b1
  } clk_src_e;
endpackage

// File: rtl/olc_rise_det.sv
module olc_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic seen_q;

  // held high through reset so a source already high gives no edge
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b1;
    else     seen_q <= level;
  end

  assign rise = level & ~seen_q;
endmodule

// File: rtl/olc_flop.sv
module olc_flop
  import olc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  flop_mode_e mode,
  input  clk_src_e   src_sel,
  input  logic       term_clk,
  input  logic       pin_clk,
  input  logic       sum,
  input  logic       arst,
  input  logic       preset,
  input  logic       load_en,
  input  logic       load_val,
  output logic       q_vis
);
  logic src_lvl;
  logic act_edge;
  logic q_r;
  logic q_nxt;

  assign src_lvl = (src_sel == SRC_PIN) ? pin_clk : term_clk;

  olc_rise_det edge_i (
    .clk   (clk),
    .rst   (rst),
    .level (src_lvl),
    .rise  (act_edge)
  );

  always_comb begin
    q_nxt = q_r;
    if (arst)          q_nxt = 1'b0;
    else if (load_en)  q_nxt = load_val;
    else if (act_edge) begin
      if (preset)                   q_nxt = 1'b1;
      else if (mode == MODE_TOGGLE) q_nxt = q_r ^ sum;
      else                          q_nxt = sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= q_nxt;
  end

  // reset term acts at once on the visible value
  assign q_vis = q_r & ~arst;
endmodule

// File: rtl/olc_cell.sv
module olc_cell
  import olc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pin_clk,
  input  logic                     preset,
  input  logic                     load_en,
  input  logic [REGS_PER_CELL-1:0] sum,
  input  logic [REGS_PER_CELL-1:0] term_clk,
  input  logic [REGS_PER_CELL-1:0] arst,
  input  logic [REGS_PER_CELL-1:0] mode_tog,
  input  logic [REGS_PER_CELL-1:0] use_pin_clk,
  input  logic [REGS_PER_CELL-1:0] load_val,
  input  logic                     sel_second,
  input  logic                     oe_term,
  output logic [REGS_PER_CELL-1:0] q,
  output logic                     pad_out,
  output logic                     pad_oe
);
  for (genvar k = 0; k < REGS_PER_CELL; k++) begin : g_reg
    olc_flop flop_i (
      .clk      (clk),
      .rst      (rst),
      .mode     (flop_mode_e'(mode_tog[k])),
      .src_sel  (clk_src_e'(use_pin_clk[k])),
      .term_clk (term_clk[k]),
      .pin_clk  (pin_clk),
      .sum      (sum[k]),
      .arst     (arst[k]),
      .preset   (preset),
      .load_en  (load_en),
      .load_val (load_val[k]),
      .q_vis    (q[k])
    );
  end

  assign pad_out = sel_second ? q[1] : q[0];
  assign pad_oe  = oe_term;
endmodule

// File: rtl/olc_bank.sv
module olc_bank
  import olc_pkg::*;
#(
  parameter int NUM_CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_pin,
  input  logic                 sync_preset,
  input  logic                 load_en,
  input  logic [NUM_CELLS-1:0] load_a,
  input  logic [NUM_CELLS-1:0] load_b,
  input  logic [NUM_CELLS-1:0] sum_a,
  input  logic [NUM_CELLS-1:0] sum_b,
  input  logic [NUM_CELLS-1:0] tclk_a,
  input  logic [NUM_CELLS-1:0] tclk_b,
  input  logic [NUM_CELLS-1:0] arst_a,
  input  logic [NUM_CELLS-1:0] arst_b,
  input  logic [NUM_CELLS-1:0] oe_term,
  input  logic [NUM_CELLS-1:0] cfg_tog_a,
  input  logic [NUM_CELLS-1:0] cfg_tog_b,
  input  logic [NUM_CELLS-1:0] cfg_pinclk_a,
  input  logic [NUM_CELLS-1:0] cfg_pinclk_b,
  input  logic [NUM_CELLS-1:0] cfg_pin_sel,
  input  logic [NUM_CELLS-1:0] pad_in,
  output logic [NUM_CELLS-1:0] pad_out,
  output logic [NUM_CELLS-1:0] pad_oe,
  output logic [NUM_CELLS-1:0] fb_a,
  output logic [NUM_CELLS-1:0] fb_b,
  output logic [NUM_CELLS-1:0] fb_pad
);
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic [REGS_PER_CELL-1:0] cell_q;

    olc_cell cell_i (
      .clk         (clk),
      .rst         (rst),
      .pin_clk     (clk_pin),
      .preset      (sync_preset),
      .load_en     (load_en),
      .sum         ({sum_b[c], sum_a[c]}),
      .term_clk    ({tclk_b[c], tclk_a[c]}),
      .arst        ({arst_b[c], arst_a[c]}),
      .mode_tog    ({cfg_tog_b[c], cfg_tog_a[c]}),
      .use_pin_clk ({cfg_pinclk_b[c], cfg_pinclk_a[c]}),
      .load_val    ({load_b[c], load_a[c]}),
      .sel_second  (cfg_pin_sel[c]),
      .oe_term     (oe_term[c]),
      .q           (cell_q),
      .pad_out     (pad_out[c]),
      .pad_oe      (pad_oe[c])
    );

    assign fb_a[c] = cell_q[0];
    assign fb_b[c] = cell_q[1];
  end

  // pin level returns to the array on its own path
  assign fb_pad = pad_in;
endmodule

// File: rtl/olc_bank_chk.sv
module olc_bank_chk #(
  parameter int NUM_CELLS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clk_pin,
  input logic                 sync_preset,
  input logic                 load_en,
  input logic [NUM_CELLS-1:0] load_b,
  input logic [NUM_CELLS-1:0] arst_a,
  input logic [NUM_CELLS-1:0] arst_b,
  input logic [NUM_CELLS-1:0] cfg_pinclk_a,
  input logic [NUM_CELLS-1:0] fb_a,
  input logic [NUM_CELLS-1:0] fb_b
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (fb_a == '0 && fb_b == '0));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    // R6: stored value is 0 after a reset-term edge
    a_r6_arst_clears: assert property (@(posedge clk) disable iff (rst)
      arst_a[i] |=> !fb_a[i]);

    // R4: pin-clocked register holds while pin is sampled low
    a_r4_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
      (cfg_pinclk_a[i] && !clk_pin && !load_en && !arst_a[i])
        |=> (arst_a[i] || fb_a[i] == $past(fb_a[i])));

    // R7: preset on a pin edge sets the register
    a_r7_preset_sets: assert property (@(posedge clk) disable iff (rst)
      (cfg_pinclk_a[i] && clk_pin && !$past(clk_pin) && !$past(rst) &&
       sync_preset && !load_en && !arst_a[i])
        |=> (fb_a[i] || arst_a[i]));

    // R9: preload stores its bit
    a_r9_preload_stores: assert property (@(posedge clk) disable iff (rst)
      (load_en && !arst_b[i])
        |=> (arst_b[i] || fb_b[i] == $past(load_b[i])));
  end
endmodule

bind olc_bank olc_bank_chk #(.NUM_CELLS(NUM_CELLS)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .clk_pin      (clk_pin),
  .sync_preset  (sync_preset),
  .load_en      (load_en),
  .load_b       (load_b),
  .arst_a       (arst_a),
  .arst_b       (arst_b),
  .cfg_pinclk_a (cfg_pinclk_a),
  .fb_a         (fb_a),
  .fb_b         (fb_b)
);

// File: tb/olc_bank_tb_top.sv
module olc_bank_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_pin = 1'b0, sync_preset = 1'b0, load_en = 1'b0;
  logic [N-1:0] load_a = '0, load_b = '0, sum_a = '0, sum_b = '0;
  logic [N-1:0] tclk_a = '0, tclk_b = '0, arst_a = '0, arst_b = '0;
  logic [N-1:0] oe_term = '0, pad_in = '0;
  logic [N-1:0] cfg_tog_a = '0, cfg_tog_b = '0;
  logic [N-1:0] cfg_pinclk_a = '0, cfg_pinclk_b = '0, cfg_pin_sel = '0;
  logic [N-1:0] pad_out, pad_oe, fb_a, fb_b, fb_pad;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference state
  logic [N-1:0] m_qa = '0, m_qb = '0, m_pa = '1, m_pb = '1;

  always #5 clk = ~clk;

  olc_bank #(.NUM_CELLS(N)) dut_i (
    .clk(clk), .rst(rst), .clk_pin(clk_pin), .sync_preset(sync_preset),
    .load_en(load_en), .load_a(load_a), .load_b(load_b),
    .sum_a(sum_a), .sum_b(sum_b), .tclk_a(tclk_a), .tclk_b(tclk_b),
    .arst_a(arst_a), .arst_b(arst_b), .oe_term(oe_term),
    .cfg_tog_a(cfg_tog_a), .cfg_tog_b(cfg_tog_b),
    .cfg_pinclk_a(cfg_pinclk_a), .cfg_pinclk_b(cfg_pinclk_b),
    .cfg_pin_sel(cfg_pin_sel), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_a(fb_a), .fb_b(fb_b),
    .fb_pad(fb_pad)
  );

  function automatic logic next_q(logic q, logic edge_seen, logic tog,
                                  logic sum, logic ar, logic ld, logic ldv);
    if (rst)                  return 1'b0;
    if (ar)                   return 1'b0;
    if (ld)                   return ldv;
    if (!edge_seen)           return q;
    if (sync_preset)          return 1'b1;
    if (tog)                  return q ^ sum;
    return sum;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic sa, sb;
      sa = cfg_pinclk_a[i] ? clk_pin : tclk_a[i];
      sb = cfg_pinclk_b[i] ? clk_pin : tclk_b[i];
      m_qa[i] = next_q(m_qa[i], sa && !m_pa[i], cfg_tog_a[i], sum_a[i],
                       arst_a[i], load_en, load_a[i]);
      m_qb[i] = next_q(m_qb[i], sb && !m_pb[i], cfg_tog_b[i], sum_b[i],
                       arst_b[i], load_en, load_b[i]);
      m_pa[i] = rst ? 1'b1 : sa;
      m_pb[i] = rst ? 1'b1 : sb;
    end
  end

  task automatic check_vec(string what, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] ea, eb, ep;
    ea = m_qa & ~arst_a;
    eb = m_qb & ~arst_b;
    for (int i = 0; i < N; i++) ep[i] = cfg_pin_sel[i] ? eb[i] : ea[i];
    check_vec("fb_a", fb_a, ea);
    check_vec("fb_b", fb_b, eb);
    check_vec("pad_out", pad_out, ep);
    check_vec("pad_oe", pad_oe, oe_term);
    check_vec("fb_pad", fb_pad, pad_in);
  endtask

  // one cycle: check at negedge, then drive new inputs
  task automatic run(int cycles, bit clocks, bit sums, int p_ar, int p_ld,
                     int p_pre);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      if (clocks) begin
        clk_pin = 1'($urandom_range(0, 1));
        tclk_a  = N'($urandom);
        tclk_b  = N'($urandom);
      end
      if (sums) begin
        sum_a = N'($urandom);
        sum_b = N'($urandom);
      end
      for (int i = 0; i < N; i++) begin
        arst_a[i] = ($urandom_range(0, 99) < p_ar);
        arst_b[i] = ($urandom_range(0, 99) < p_ar);
      end
      load_en     = ($urandom_range(0, 99) < p_ld);
      load_a      = N'($urandom);
      load_b      = N'($urandom);
      sync_preset = ($urandom_range(0, 99) < p_pre);
      oe_term     = N'($urandom);
      pad_in      = N'($urandom);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with clocks and sums active
    tag = "R1";
    cfg_tog_a = 4'b1010; cfg_tog_b = 4'b0101;
    cfg_pinclk_a = 4'b1100; cfg_pinclk_b = 4'b0110;
    cfg_pin_sel = 4'b1010;
    clk_pin = 1'b1; tclk_a = '1; tclk_b = '1; sum_a = '1; sum_b = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1"; check_vec("fb_a after reset", fb_a, '0);
    check_vec("fb_b after reset", fb_b, '0);
    // R4: sources held high since reset give no edge
    @(negedge clk);
    tag = "R4"; check_vec("no edge from held-high source", fb_a | fb_b, '0);

    tag = "R2 R3 R5 R10"; run(400, 1, 1, 0, 0, 0);
    tag = "R4";           run(100, 0, 1, 0, 0, 0);
    tag = "R6";           run(300, 1, 1, 20, 0, 0);
    tag = "R7";           run(300, 1, 1, 0, 0, 30);
    tag = "R9";           run(200, 1, 1, 0, 40, 10);
    tag = "R8";           run(300, 1, 1, 30, 30, 40);
    tag = "R11";          run(100, 1, 1, 10, 10, 10);

    // second configuration, swapped modes
    @(negedge clk);
    rst = 1'b1;
    cfg_tog_a = ~cfg_tog_a; cfg_tog_b = ~cfg_tog_b;
    cfg_pinclk_a = ~cfg_pinclk_a; cfg_pinclk_b = ~cfg_pinclk_b;
    cfg_pin_sel = ~cfg_pin_sel;
    tag = "R1"; run(3, 1, 1, 0, 0, 0);
    rst = 1'b0;
    tag = "R2 R3 R5 R10"; run(400, 1, 1, 0, 0, 0);
    tag = "R8";           run(400, 1, 1, 15, 15, 30);

    // R9 directed: preload all ones into first registers
    @(negedge clk);
    arst_a = '0; arst_b = '0; sync_preset = 1'b0;
    load_en = 1'b1; load_a = '1; load_b = '0;
    @(negedge clk);
    load_en = 1'b0; clk_pin = 1'b0; tclk_a = '1; tclk_b = '1;
    tag = "R9"; check_vec("preload ones", fb_a, '1);
    check_vec("preload zeros", fb_b, '0);
    // R6 directed: reset term visible in same cycle
    arst_a = 4'b0101;
    #1;
    tag = "R6"; check_vec("same-cycle clear", fb_a, 4'b1010);
    @(negedge clk);
    arst_a = '0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule